// File: doc/BRIEF.md
# Programmable Countdown Timer

The block is a down-counting timer that advances on a base tick input after a selectable power-of-two prescaler. Software sets three registers through a small write/read port: a divider setting, a start value, and a control entry that holds an 8-bit vector, a mask flag and a repeat flag. A fourth address returns the live count and cannot be written.

When the count runs out, the block raises a one-cycle request that carries the vector. In single-shot mode the count stops at zero and the request is raised once. In repeat mode the count reloads and the request recurs at a fixed period. A start value of zero keeps the timer silent in both modes. Writing the start value restarts the count and the prescaler phase in the same cycle.

Top module: `cdt_timer`

## Requirements
- R1: After reset the divider reads 0, the start value reads 0, the live count reads 0, the control entry reads 0x00010000 (masked, single-shot, vector 0), and no request is raised.
- R2: A divider write keeps only bits 3, 1 and 0 (mask 0xB). The other bits read back as 0.
- R3: The divider code is v = {bit3, bit1, bit0}, and shift = (v+1) mod 8. The count steps once every 2^shift base ticks, so code 7 (write 0xB) steps on every tick, code 2 (write 0x2) every 8 ticks and code 4 (write 0x8) every 32 ticks. Addresses: 0 divider, 1 start value, 2 control entry, 3 live count.
- R4: A start-value write loads the count and restarts the prescaler. After k scaled steps the live count reads start−k, and it never rises except through a load or a repeat reload.
- R5: In single-shot mode the count stops at 0. One request is raised at scaled step start+1 and no further requests follow.
- R6: In repeat mode (bit 17) a request is raised every start+1 scaled steps, and the count reloads to the start value at each request.
- R7: With a start value of 0, no request is raised in either mode.
- R8: While the entry is masked (bit 16), no request is raised and the count keeps running. A single-shot expiry that occurs while masked is consumed.
- R9: A request is `irq_valid` high for exactly one cycle, in the cycle after the expiring step. `irq_vector` carries bits [7:0] of the entry as they stood at that step.
- R10: A write to the live-count address has no effect. While `tick` is low the count holds.
- R11: The entry keeps bit 17 (repeat), bit 16 (mask) and bits [7:0] (vector), and reads other bits as 0. An entry write re-arms a single-shot count only if the live count is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Base tick enable |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Write address |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 2 | Read address |
| reg_rdata | output | 32 | Read data (combinational) |
| irq_valid | output | 1 | One-cycle expiry request |
| irq_vector | output | 8 | Vector carried with the request |

## Verification
A wrong count or prescaler phase shows up directly in the cycle on which `irq_valid` rises. The bench compares every request against a cycle predicted from the start value and the divider, so an error of a single step is visible at the first expiry. A stale armed flag or mask decision appears as a missing or extra request within one period. Corrupted registers are caught by reading the live count at chosen cycles and by reading back the other registers.

// File: rtl/cdt_pkg.sv
`timescale 1ns/1ps
package cdt_pkg;
    localparam int DATA_W = 32;
    localparam int AW     = 2;

    localparam logic [AW-1:0] ADR_DIV   = 2'd0;
    localparam logic [AW-1:0] ADR_INIT  = 2'd1;
    localparam logic [AW-1:0] ADR_ENTRY = 2'd2;
    localparam logic [AW-1:0] ADR_CUR   = 2'd3;

    localparam int REPEAT_BIT = 17;
    localparam int MASK_BIT   = 16;

    typedef struct packed {
        logic       repeat_en;
        logic       masked;
        logic [7:0] vector;
    } entry_t;

    localparam entry_t ENTRY_RESET = '{repeat_en: 1'b0, masked: 1'b1, vector: 8'h00};

    // Scattered divider code to prescaler shift
    function automatic logic [2:0] shift_of(input logic [3:0] div);
        logic [2:0] v;
        v = {div[3], div[1], div[0]};
        return v + 3'd1;
    endfunction

    function automatic entry_t entry_from_word(input logic [DATA_W-1:0] w);
        entry_t e;
        e.repeat_en = w[REPEAT_BIT];
        e.masked    = w[MASK_BIT];
        e.vector    = w[7:0];
        return e;
    endfunction

    function automatic logic [DATA_W-1:0] entry_to_word(input entry_t e);
        logic [DATA_W-1:0] w;
        w = '0;
        w[REPEAT_BIT] = e.repeat_en;
        w[MASK_BIT]   = e.masked;
        w[7:0]        = e.vector;
        return w;
    endfunction
endpackage

// File: rtl/cdt_prescale.sv
`timescale 1ns/1ps
module cdt_prescale #(
    parameter int PRE_W = 8,
    parameter int SH_W  = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            restart,
    input  logic [SH_W-1:0] shift,
    output logic            step
);
    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] sel_mask;

    assign sel_mask = (PRE_W'(1) << shift) - PRE_W'(1);
    assign step     = tick && !restart && ((pre_cnt & sel_mask) == sel_mask);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pre_cnt <= '0;
        end else if (tick) begin
            pre_cnt <= pre_cnt + PRE_W'(1);
        end
    end
endmodule

// File: rtl/cdt_regs.sv
`timescale 1ns/1ps
module cdt_regs
    import cdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    input  logic [CNT_W-1:0]  cur,
    output logic [DATA_W-1:0] rdata,
    output logic [3:0]        div_q,
    output logic [CNT_W-1:0]  init_q,
    output entry_t            entry_q,
    output logic              load,
    output logic              entry_wr
);
    assign load     = wr && (waddr == ADR_INIT);
    assign entry_wr = wr && (waddr == ADR_ENTRY);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q   <= '0;
            init_q  <= '0;
            entry_q <= ENTRY_RESET;
        end else if (wr) begin
            case (waddr)
                ADR_DIV:   div_q   <= wdata[3:0] & 4'hB;
                ADR_INIT:  init_q  <= wdata[CNT_W-1:0];
                ADR_ENTRY: entry_q <= entry_from_word(wdata);
                default:   ;
            endcase
        end
    end

    always_comb begin
        case (raddr)
            ADR_DIV:   rdata = DATA_W'(div_q);
            ADR_INIT:  rdata = DATA_W'(init_q);
            ADR_ENTRY: rdata = entry_to_word(entry_q);
            default:   rdata = DATA_W'(cur);
        endcase
    end
endmodule

// File: rtl/cdt_core.sv
`timescale 1ns/1ps
module cdt_core
    import cdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] init_val,
    input  logic             entry_wr,
    input  entry_t           entry,
    output logic [CNT_W-1:0] cur,
    output logic             irq_valid,
    output logic [7:0]       irq_vector
);
    logic armed;
    logic at_zero;
    logic expire;

    assign at_zero = (cur == '0);
    assign expire  = step && at_zero &&
                     (entry.repeat_en ? (init_val != '0) : armed);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur        <= '0;
            armed      <= 1'b0;
            irq_valid  <= 1'b0;
            irq_vector <= '0;
        end else begin
            irq_valid <= expire && !entry.masked;
            if (expire) begin
                irq_vector <= entry.vector;
            end
            if (load) begin
                cur   <= load_val;
                armed <= (load_val != '0);
            end else begin
                if (step) begin
                    if (!at_zero) begin
                        cur <= cur - CNT_W'(1);
                    end else if (expire && entry.repeat_en) begin
                        cur <= init_val;
                    end
                end
                if (entry_wr) begin
                    armed <= !at_zero;
                end else if (expire && !entry.repeat_en) begin
                    armed <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/cdt_timer.sv
`timescale 1ns/1ps
module cdt_timer
    import cdt_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PRE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              reg_wr,
    input  logic [AW-1:0]     reg_waddr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [AW-1:0]     reg_raddr,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_valid,
    output logic [7:0]        irq_vector
);
    localparam int SH_W = 3;

    logic [3:0]       div_q;
    logic [CNT_W-1:0] init_q;
    entry_t           entry_q;
    logic             load;
    logic             entry_wr;
    logic             step;
    logic [CNT_W-1:0] cur_count;
    logic             entry_masked;
    logic             entry_repeat;

    assign entry_masked = entry_q.masked;
    assign entry_repeat = entry_q.repeat_en;

    cdt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .waddr(reg_waddr), .wdata(reg_wdata),
        .raddr(reg_raddr), .cur(cur_count), .rdata(reg_rdata), .div_q(div_q),
        .init_q(init_q), .entry_q(entry_q), .load(load), .entry_wr(entry_wr)
    );

    cdt_prescale #(.PRE_W(PRE_W), .SH_W(SH_W)) u_pre (
        .clk(clk), .rst(rst), .tick(tick), .restart(load),
        .shift(shift_of(div_q)), .step(step)
    );

    cdt_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst(rst), .step(step), .load(load),
        .load_val(reg_wdata[CNT_W-1:0]), .init_val(init_q),
        .entry_wr(entry_wr), .entry(entry_q), .cur(cur_count),
        .irq_valid(irq_valid), .irq_vector(irq_vector)
    );
endmodule

// File: rtl/cdt_checker.sv
`timescale 1ns/1ps
module cdt_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic [1:0]       reg_raddr,
    input logic [31:0]      reg_rdata,
    input logic             irq_valid,
    input logic [CNT_W-1:0] cur,
    input logic             masked,
    input logic             repeat_en,
    input logic             step,
    input logic             load
);
    // R9: the request lasts exactly one cycle
    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        irq_valid |=> !irq_valid);

    // R9: a request follows a prescaled step
    assert_after_step_R9: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> $past(step));

    // R8: no request while masked
    assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> !$past(masked));

    // R5: a single-shot count at zero stays at zero
    assert_oneshot_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!repeat_en && cur == '0 && !load) |=> (cur == '0));

    // R4: a non-zero count never rises without a load
    assert_count_down_R4: assert property (@(posedge clk) disable iff (rst)
        (!load && cur != '0) |=> (cur <= $past(cur)));

    // R10: without a tick the count holds
    assert_tick_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(cur));

    // R2: unused divider bits read as zero
    assert_div_bits_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_raddr == 2'd0) |-> (reg_rdata[31:4] == '0 && reg_rdata[2] == 1'b0));
endmodule

bind cdt_timer cdt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .irq_valid(irq_valid), .cur(cur_count), .masked(entry_masked),
    .repeat_en(entry_repeat), .step(step), .load(load)
);

// File: tb/cdt_timer_test.sv
`timescale 1ns/1ps
module cdt_timer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [1:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic        irq_valid;
    logic [7:0]  irq_vector;

    always #2.5 clk = ~clk;

    cdt_timer uut (
        .clk(clk), .rst(rst), .tick(tick), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .irq_valid(irq_valid), .irq_vector(irq_vector)
    );

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit done = 0;

    typedef struct {
        int         at;
        logic [7:0] vec;
        string      tag;
    } exp_t;
    exp_t q[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, output int e);
        reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        e = cyc;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_raddr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic expect_irq(input int at, input logic [7:0] v, input string tag);
        exp_t e;
        e.at = at; e.vec = v; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // Monitor: compare each request against the scoreboard
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (irq_valid) begin
                checks++;
                if (q.size() == 0) begin
                    fails++;
                    $display("FAIL R8 unexpected request got cycle=%0d vec=%h expected none", cyc, irq_vector);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (e.at != cyc || e.vec != irq_vector) begin
                        fails++;
                        $display("FAIL %s got cycle=%0d vec=%h expected cycle=%0d vec=%h",
                                 e.tag, cyc, irq_vector, e.at, e.vec);
                    end
                end
            end else if (q.size() > 0 && q[0].at < cyc) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                fails++;
                $display("FAIL %s got no request expected cycle=%0d vec=%h", e.tag, e.at, e.vec);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog got timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        int e;
        int e2;
        logic [31:0] d;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'd0, d); chk("R1 divider", d, 32'h0);
        rd(2'd1, d); chk("R1 start", d, 32'h0);
        rd(2'd2, d); chk("R1 entry", d, 32'h0001_0000);
        rd(2'd3, d); chk("R1 count", d, 32'h0);
        chk("R1 no request", {31'b0, irq_valid}, 32'h0);

        // R2 divider bit keeping
        wr(2'd0, 32'hFFFF_FFFF, e); rd(2'd0, d); chk("R2 divider all ones", d, 32'hB);
        wr(2'd0, 32'h0000_0006, e); rd(2'd0, d); chk("R2 divider 0x6", d, 32'h2);

        // R11 entry fields
        wr(2'd2, 32'hFFFC_FF41, e); rd(2'd2, d); chk("R11 entry fields", d, 32'h0000_0041);
        wr(2'd2, 32'h0003_0055, e); rd(2'd2, d); chk("R11 entry flags", d, 32'h0003_0055);

        // R3 code 7, R4, R5 single shot
        wr(2'd0, 32'hB, e);
        wr(2'd2, 32'h0000_0041, e);
        wr(2'd1, 32'd5, e);
        expect_irq(e + 6, 8'h41, "R5 single-shot request");
        rd(2'd3, d); chk("R4 load value", d, 32'd5);
        wait_until(e + 2); rd(2'd3, d); chk("R4 count after 2 steps", d, 32'd3);
        wait_until(e + 10); rd(2'd3, d); chk("R5 count stops at zero", d, 32'd0);
        wait_until(e + 30);

        // R6 repeat, code 0 (2 ticks per step)
        wr(2'd0, 32'h0, e);
        wr(2'd2, 32'h0002_0022, e);
        wr(2'd1, 32'd3, e);
        expect_irq(e + 8,  8'h22, "R6 repeat request 1");
        expect_irq(e + 16, 8'h22, "R6 repeat request 2");
        expect_irq(e + 24, 8'h22, "R6 repeat request 3");
        wait_until(e + 18); rd(2'd3, d); chk("R6 reload count", d, 32'd2);
        wait_until(e + 26);
        wr(2'd2, 32'h0003_0022, e2);
        wait_until(e + 36); rd(2'd3, d); chk("R8 count runs while masked", d, 32'd1);
        wait_until(e + 50);

        // R3 code 2: 8 ticks per step
        wr(2'd0, 32'h2, e);
        wr(2'd2, 32'h0000_0077, e);
        wr(2'd1, 32'd2, e);
        expect_irq(e + 24, 8'h77, "R3 code 2 request");
        wait_until(e + 7); rd(2'd3, d); chk("R3 code 2 before step", d, 32'd2);
        wait_until(e + 8); rd(2'd3, d); chk("R3 code 2 first step", d, 32'd1);
        wait_until(e + 30);

        // R3 code 4 via bit 3: 32 ticks per step
        wr(2'd0, 32'h8, e);
        wr(2'd2, 32'h0000_0033, e);
        wr(2'd1, 32'd1, e);
        expect_irq(e + 64, 8'h33, "R3 code 4 request");
        wait_until(e + 31); rd(2'd3, d); chk("R3 code 4 before step", d, 32'd1);
        wait_until(e + 32); rd(2'd3, d); chk("R3 code 4 first step", d, 32'd0);
        wait_until(e + 80);

        // R7 zero start value
        wr(2'd0, 32'hB, e);
        wr(2'd2, 32'h0002_0044, e);
        wr(2'd1, 32'd0, e);
        wait_until(e + 20); rd(2'd3, d); chk("R7 repeat zero count", d, 32'd0);
        wr(2'd2, 32'h0000_0044, e);
        wait_until(e + 20); rd(2'd3, d); chk("R7 single-shot zero count", d, 32'd0);

        // R8 masked single-shot expiry is consumed; R11 no re-arm at zero
        wr(2'd2, 32'h0001_0055, e);
        wr(2'd1, 32'd3, e);
        wait_until(e + 10); rd(2'd3, d); chk("R8 masked count reaches zero", d, 32'd0);
        wr(2'd2, 32'h0000_0055, e);
        wait_until(e + 20); rd(2'd3, d); chk("R11 unmask at zero stays idle", d, 32'd0);

        // R10 tick low and write to live count
        wr(2'd2, 32'h0001_0000, e);
        wr(2'd1, 32'd100, e);
        tick = 1'b0;
        wait_until(e + 5); rd(2'd3, d); chk("R10 tick low holds", d, 32'd100);
        wr(2'd3, 32'd7, e); rd(2'd3, d); chk("R10 count write ignored", d, 32'd100);
        tick = 1'b1;
        wait_until(e + 3); rd(2'd3, d); chk("R10 resumes after tick", d, 32'd97);

        // R4 restart mid-run
        wr(2'd2, 32'h0000_0066, e);
        wr(2'd1, 32'd10, e);
        wait_until(e + 4); rd(2'd3, d); chk("R4 running count", d, 32'd6);
        wr(2'd1, 32'd4, e2);
        expect_irq(e2 + 5, 8'h66, "R4 restarted request");
        rd(2'd3, d); chk("R4 restart value", d, 32'd4);
        wait_until(e2 + 15);

        chk("R9 scoreboard drained", q.size(), 32'd0);
        done = 1;
        report();
        $finish;
    end
endmodule